// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Controller

This block holds the status word of a floating-point unit and decides, for each completed arithmetic operation, whether the operation ends in a trap. The word has five parts: a current-exception field, an accrued-exception field, a five-bit trap-enable mask, a nonstandard-mode bit and a two-bit condition code. When an operation completes, the datapath presents the five IEEE flags it raised, its new condition code, its result value, a flag for an unfinished or unimplemented operation, and a flag for a subnormal operand or result.

The block combines the flags with the mask. In the same cycle it either signals a trap and blocks the architectural updates, or lets the result write through and folds the flags into the status word. Software can load the whole word through a write port, and that is the only way to clear the accrued flags. In nonstandard mode a subnormal case is flushed to zero and cannot request an underflow trap.

Top module: `fpstat_trap_ctrl`

## Requirements
- R1: After reset every bit of `stat_word` is zero. The layout is: current flags in bits [4:0], accrued flags in [9:5], trap mask in [14:10], nonstandard bit at 15, condition code in [17:16]. Inside each 5-bit field, bit 4 is invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact.
- R2: `trap_pulse` is high in the same cycle as a completing operation (`op_valid`) exactly when the bitwise AND of its effective flags and the mask is nonzero, or when `op_unfin` is set. It is low in every other cycle.
- R3: In a trapping cycle `res_we` is low. In a completing cycle with no trap, `res_we` is high. With no completing operation it is low.
- R4: After a trapping operation, the condition code and the accrued field are unchanged.
- R5: After a trap caused by IEEE flags, the current field holds the flags that caused it (effective flags AND mask).
- R6: An operation with `op_unfin` set always traps and leaves the current field unchanged.
- R7: After a non-trapping operation, the condition code takes `op_cc` and the current field takes the effective flags.
- R8: After a non-trapping operation, the accrued field is its old value OR the effective flags. Only a software write can clear accrued bits.
- R9: With the nonstandard bit set and `op_subn` high, `res_data` is zero and the underflow flag is removed from the effective flags, so it neither traps nor accrues. In every other case `res_data` equals `op_result` and the effective flags equal `op_exc`.
- R10: A software write loads `stat_word` with `sw_wr_data` on the next clock and takes priority over an operation completing in the same cycle. The trap and write-enable outputs of that operation are still computed from the pre-write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software load of the status word |
| sw_wr_data | input | 18 | Value to load |
| op_valid | input | 1 | An operation completes this cycle |
| op_exc | input | 5 | IEEE flags raised by the operation |
| op_cc | input | 2 | New condition code |
| op_result | input | DATA_W | Result value from the datapath |
| op_unfin | input | 1 | Operation unfinished or unimplemented |
| op_subn | input | 1 | Subnormal operand or result involved |
| stat_word | output | 18 | Current status word |
| trap_pulse | output | 1 | Trap request for the completing operation |
| res_we | output | 1 | Destination register write enable |
| res_data | output | DATA_W | Result to write, flushed when required |

## Verification
The bench first tries operations whose flags all fall outside the mask, to confirm that they accumulate without trapping. It then tries flags inside the mask, which must show the trap path's suppression of the accrued and condition-code updates. An unfinished operation is sent with flags raised, which separates cause recording from the unfinished case. Subnormal underflow is tried with the nonstandard bit both on and off to separate flushing from the standard path. A software write in the same cycle as a completion tests priority. A long random stream then mixes all of these, and a behavioural model compares the outputs on every cycle.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
   localparam int NFLAG    = 5;
   localparam int FCC_W    = 2;
   // flag positions inside each field (MSB first: invalid .. inexact)
   localparam int FL_NV    = 4;
   localparam int FL_OF    = 3;
   localparam int FL_UF    = 2;
   localparam int FL_DZ    = 1;
   localparam int FL_NX    = 0;
   // status word layout
   localparam int CEXC_LSB = 0;
   localparam int AEXC_LSB = CEXC_LSB + NFLAG;
   localparam int TEM_LSB  = AEXC_LSB + NFLAG;
   localparam int NS_BIT   = TEM_LSB + NFLAG;
   localparam int FCC_LSB  = NS_BIT + 1;
   localparam int STAT_W   = FCC_LSB + FCC_W;

   typedef logic [NFLAG-1:0] flags_t;

   typedef struct packed {
      logic [FCC_W-1:0] fcc;
      logic             ns;
      flags_t           tem;
      flags_t           aexc;
      flags_t           cexc;
   } stat_t;
endpackage

// File: rtl/fpstat_flush.sv
module fpstat_flush
   import fpstat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit FLUSH_EN = 1'b1
) (
   input  logic              ns,
   input  logic              subn,
   input  flags_t            exc_in,
   input  logic [DATA_W-1:0] res_in,
   output flags_t            exc_out,
   output logic [DATA_W-1:0] res_out
);
   localparam flags_t UF_MASK = flags_t'(1) << FL_UF;

   generate
      if (FLUSH_EN) begin : g_flush
         logic do_flush;
         assign do_flush = ns & subn;
         always_comb begin
            exc_out = do_flush ? (exc_in & ~UF_MASK) : exc_in;
            res_out = do_flush ? '0 : res_in;
         end
      end else begin : g_pass
         logic unused_mode;
         assign unused_mode = ns ^ subn;
         assign exc_out = exc_in;
         assign res_out = res_in;
      end
   endgenerate
endmodule

// File: rtl/fpstat_trap_decide.sv
module fpstat_trap_decide
   import fpstat_pkg::*;
(
   input  logic   op_valid,
   input  logic   unfin,
   input  flags_t eff_exc,
   input  flags_t tem,
   output logic   trap,
   output logic   res_we,
   output flags_t cause
);
   always_comb begin
      cause  = eff_exc & tem;
      trap   = op_valid & (unfin | (|cause));
      res_we = op_valid & ~trap;
   end
endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
   import fpstat_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr_en,
   input  stat_t            sw_data,
   input  logic             op_valid,
   input  logic             trap,
   input  logic             unfin,
   input  flags_t           eff_exc,
   input  flags_t           cause,
   input  logic [FCC_W-1:0] op_cc,
   output stat_t            st
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else if (sw_wr_en) begin
         st <= sw_data;
      end else if (op_valid) begin
         if (trap) begin
            if (!unfin) st.cexc <= cause;
         end else begin
            st.cexc <= eff_exc;
            st.aexc <= st.aexc | eff_exc;
            st.fcc  <= op_cc;
         end
      end
   end
endmodule

// File: rtl/fpstat_trap_ctrl.sv
module fpstat_trap_ctrl
   import fpstat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit FLUSH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic [17:0]       sw_wr_data,
   input  logic              op_valid,
   input  logic [4:0]        op_exc,
   input  logic [1:0]        op_cc,
   input  logic [DATA_W-1:0] op_result,
   input  logic              op_unfin,
   input  logic              op_subn,
   output logic [17:0]       stat_word,
   output logic              trap_pulse,
   output logic              res_we,
   output logic [DATA_W-1:0] res_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("fpstat_trap_ctrl: DATA_W must be positive");
      end
      if (STAT_W != 18 || NFLAG != 5 || FCC_W != 2) begin : g_bad_layout
         $error("fpstat_trap_ctrl: status layout does not match port widths");
      end
   endgenerate

   stat_t  st;
   flags_t eff_exc;
   flags_t cause;

   fpstat_flush #(.DATA_W(DATA_W), .FLUSH_EN(FLUSH_EN)) u_flush (
      .ns      (st.ns),
      .subn    (op_subn),
      .exc_in  (flags_t'(op_exc)),
      .res_in  (op_result),
      .exc_out (eff_exc),
      .res_out (res_data)
   );

   fpstat_trap_decide u_decide (
      .op_valid (op_valid),
      .unfin    (op_unfin),
      .eff_exc  (eff_exc),
      .tem      (st.tem),
      .trap     (trap_pulse),
      .res_we   (res_we),
      .cause    (cause)
   );

   fpstat_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_wr_en (sw_wr_en),
      .sw_data  (stat_t'(sw_wr_data)),
      .op_valid (op_valid),
      .trap     (trap_pulse),
      .unfin    (op_unfin),
      .eff_exc  (eff_exc),
      .cause    (cause),
      .op_cc    (op_cc),
      .st       (st)
   );

   assign stat_word = st;
endmodule

// File: rtl/fpstat_trap_chk.sv
module fpstat_trap_chk
   import fpstat_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_wr_en,
   input logic [17:0]       sw_wr_data,
   input logic              op_valid,
   input logic [4:0]        op_exc,
   input logic [DATA_W-1:0] op_result,
   input logic              op_unfin,
   input logic              op_subn,
   input logic [17:0]       stat_word,
   input logic              trap_pulse,
   input logic              res_we
);
   logic [4:0] tem_w, aexc_w, cexc_w;
   logic [1:0] fcc_w;
   logic       ns_w;
   assign tem_w  = stat_word[TEM_LSB +: NFLAG];
   assign aexc_w = stat_word[AEXC_LSB +: NFLAG];
   assign cexc_w = stat_word[CEXC_LSB +: NFLAG];
   assign fcc_w  = stat_word[FCC_LSB +: FCC_W];
   assign ns_w   = stat_word[NS_BIT];

   // R3
   trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> !res_we);

   // R2
   trap_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> op_valid);

   // R6
   unfin_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_unfin) |-> trap_pulse);

   // R4
   trap_keeps_arch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pulse && !sw_wr_en) |=> ($stable(aexc_w) && $stable(fcc_w)));

   // R6
   unfin_keeps_cexc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_unfin && !sw_wr_en) |=> $stable(cexc_w));

   // R8
   accrued_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr_en |=> ((aexc_w & $past(aexc_w)) == $past(aexc_w)));

   // R10
   sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en |=> (stat_word == $past(sw_wr_data)));

   // R9
   flush_no_uf_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_unfin && ns_w && op_subn && ((op_exc & tem_w & 5'b11011) == 5'b0))
      |-> !trap_pulse);

   // R9
   no_flush_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !(ns_w && op_subn)) |-> (i_res_data_probe == op_result));

   logic [DATA_W-1:0] i_res_data_probe;
   assign i_res_data_probe = fpstat_trap_ctrl.res_data;
endmodule

bind fpstat_trap_ctrl fpstat_trap_chk #(.DATA_W(DATA_W)) i_fpstat_trap_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_wr_en   (sw_wr_en),
   .sw_wr_data (sw_wr_data),
   .op_valid   (op_valid),
   .op_exc     (op_exc),
   .op_result  (op_result),
   .op_unfin   (op_unfin),
   .op_subn    (op_subn),
   .stat_word  (stat_word),
   .trap_pulse (trap_pulse),
   .res_we     (res_we)
);

// File: tb/test_fpstat_trap_ctrl.sv
module test_fpstat_trap_ctrl;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_wr_en = 1'b0;
   logic [17:0]   sw_wr_data = '0;
   logic          op_valid = 1'b0;
   logic [4:0]    op_exc = '0;
   logic [1:0]    op_cc = '0;
   logic [DW-1:0] op_result = '0;
   logic          op_unfin = 1'b0;
   logic          op_subn = 1'b0;
   logic [17:0]   stat_word;
   logic          trap_pulse;
   logic          res_we;
   logic [DW-1:0] res_data;

   int n_chk = 0;
   int n_fail = 0;

   // behavioural reference state
   logic [4:0] m_cexc = '0, m_aexc = '0, m_tem = '0;
   logic       m_ns = 1'b0;
   logic [1:0] m_fcc = '0;

   fpstat_trap_ctrl #(.DATA_W(DW), .FLUSH_EN(1'b1)) i_fpstat_trap_ctrl (
      .clk, .rst_n, .sw_wr_en, .sw_wr_data, .op_valid, .op_exc, .op_cc,
      .op_result, .op_unfin, .op_subn, .stat_word, .trap_pulse, .res_we, .res_data
   );

   always #4 clk = ~clk;

   function automatic logic [17:0] model_word();
      return {m_fcc, m_ns, m_tem, m_aexc, m_cexc};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, compare outputs, advance model at posedge
   task automatic step(input string req, input logic sw, input logic [17:0] swd,
                       input logic v, input logic [4:0] e, input logic [1:0] cc,
                       input logic [DW-1:0] r, input logic u, input logic s);
      logic [4:0]    eff;
      logic [4:0]    cause;
      logic          tr;
      logic [DW-1:0] rexp;
      @(negedge clk);
      sw_wr_en = sw; sw_wr_data = swd; op_valid = v; op_exc = e;
      op_cc = cc; op_result = r; op_unfin = u; op_subn = s;
      #1;
      eff   = (m_ns && s) ? (e & 5'b11011) : e;   // R9 underflow is bit 2
      rexp  = (m_ns && s) ? '0 : r;
      cause = eff & m_tem;
      tr    = v && (u || (cause != 0));
      chk(req, "stat_word", DW'(stat_word), DW'(model_word()));
      chk(req, "trap_pulse", DW'(trap_pulse), DW'(tr));
      chk(req, "res_we", DW'(res_we), DW'(v && !tr));
      chk(req, "res_data", res_data, rexp);
      @(posedge clk);
      if (sw) begin
         {m_fcc, m_ns, m_tem, m_aexc, m_cexc} = swd;
      end else if (v) begin
         if (tr) begin
            if (!u) m_cexc = cause;
         end else begin
            m_cexc = eff;
            m_aexc = m_aexc | eff;
            m_fcc  = cc;
         end
      end
   endtask

   task automatic idle(input string req);
      step(req, 1'b0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "reset stat_word", DW'(stat_word), '0);
      rst_n = 1'b1;

      // R7 clean op, no flags, no trap
      step("R7", 1'b0, '0, 1'b1, 5'b00000, 2'd1, 32'h1111_0000, 1'b0, 1'b0);
      // R8 inexact with all traps off accumulates
      step("R8", 1'b0, '0, 1'b1, 5'b00001, 2'd2, 32'h2222_0000, 1'b0, 1'b0);
      idle("R8");
      chk("R8", "accrued inexact", DW'(stat_word[9:5]), DW'(5'b00001));
      // R10 software enables invalid trap, keeps accrued
      step("R10", 1'b1, {2'd2, 1'b0, 5'b10000, 5'b00001, 5'b00000},
           1'b0, '0, '0, '0, 1'b0, 1'b0);
      // R2 R3 R4 R5 invalid + inexact with invalid enabled
      step("R2", 1'b0, '0, 1'b1, 5'b10001, 2'd3, 32'h3333_0000, 1'b0, 1'b0);
      idle("R4");
      chk("R5", "cexc cause", DW'(stat_word[4:0]), DW'(5'b10000));
      chk("R4", "fcc kept", DW'(stat_word[17:16]), DW'(2'd2));
      // R8 overflow not enabled accumulates
      step("R8", 1'b0, '0, 1'b1, 5'b01000, 2'd0, 32'h4444_0000, 1'b0, 1'b0);
      // R6 unfinished with a flag raised
      step("R6", 1'b0, '0, 1'b1, 5'b00010, 2'd1, 32'h5555_0000, 1'b1, 1'b0);
      idle("R6");
      chk("R6", "cexc kept", DW'(stat_word[4:0]), DW'(5'b01000));
      // R9 nonstandard, underflow enabled, subnormal result flushed
      step("R9", 1'b1, {2'd0, 1'b1, 5'b00100, 5'b00000, 5'b00000},
           1'b0, '0, '0, '0, 1'b0, 1'b0);
      step("R9", 1'b0, '0, 1'b1, 5'b00101, 2'd1, 32'h0000_0abc, 1'b0, 1'b1);
      idle("R9");
      chk("R9", "no underflow accrued", DW'(stat_word[9:5]), DW'(5'b00001));
      // R9 standard mode: same op traps
      step("R9", 1'b1, {2'd0, 1'b0, 5'b00100, 5'b00000, 5'b00000},
           1'b0, '0, '0, '0, 1'b0, 1'b0);
      step("R9", 1'b0, '0, 1'b1, 5'b00101, 2'd1, 32'h0000_0abc, 1'b0, 1'b1);
      // R10 software write wins over completing op
      step("R10", 1'b1, 18'h2AAAA, 1'b1, 5'b00011, 2'd3, 32'h6666_0000, 1'b0, 1'b0);
      idle("R10");
      chk("R10", "sw priority", DW'(stat_word), DW'(18'h2AAAA));
      // R8 software write clears accrued
      step("R8", 1'b1, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0);
      idle("R8");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic sw;
         sw = ($urandom_range(0, 9) == 0);
         step("R2", sw, 18'($urandom), ($urandom_range(0, 3) != 0),
              5'($urandom), 2'($urandom), 32'($urandom),
              ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0));
      end
      idle("R7");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule